// File: doc/BRIEF.md
# Multiply, Divide and Accumulate Unit

This block sits beside an integer pipeline and performs integer multiplication, multiply-accumulate and division on two W-bit register operands. It holds a 2W-bit result pair made of a high word (HI) and a low word (LO). A multiply places the upper half of the product in HI and the lower half in LO. A multiply-accumulate adds the product into the existing HI/LO pair. A divide leaves the quotient in LO and the remainder in HI. Signed and unsigned forms exist for every operation.

The parameter `FAST_BUILD` selects one of two builds. The fast build has a W x (W/2) signed multiply array. A multiply whose second operand fits in a half word finishes in one cycle. Any other multiply takes two passes through the array. The small build has a shift-and-add engine that retires one multiplier bit per clock, so every multiply takes W cycles. Both builds share an iterative divider with a fixed latency of `DIV_LAT` cycles.

A request is accepted when `req_valid` and `req_ready` are both high. While an operation is in progress, the pipeline keeps issuing unrelated instructions, and only a read of HI/LO is stalled. A second request that arrives during that time waits for the unit to become idle and does not abort the operation in progress.

Top module: `muldiv_unit`

## Requirements
- R1: After a synchronous reset, HI and LO are zero, `busy` is low and `req_ready` is high.
- R2: Opcode bits [2:1] select the class: 00 is multiply, 01 is multiply-accumulate, 10 is divide and 11 is reserved. Bit 0 set means unsigned and bit 0 clear means signed. A multiply leaves the upper W bits of the 2W-bit product in HI and the lower W bits in LO.
- R3: A multiply-accumulate replaces {HI,LO} with {HI,LO} plus the 2W-bit product, wrapping modulo 2^(2W), in both the signed and the unsigned form.
- R4: A divide with a non-zero divisor leaves the quotient in LO, truncated toward zero, and the remainder in HI, carrying the sign of the dividend. A signed divide of the most negative value by -1 gives LO equal to that same most negative value and HI equal to 0.
- R5: A divide by zero leaves HI equal to the dividend. LO is all ones, except that a signed divide with a negative dividend leaves LO equal to 1. No error is raised.
- R6: Latency L is the rising edge, counting the accepting edge as edge 1, after which HI/LO hold the result; `busy` is high between the accepting edge and edge L. In the fast build, a multiply or multiply-accumulate has L=1 when the second operand fits in W/2 bits, and L=2 otherwise. The second operand fits when its upper half is all zero for an unsigned operation, or equals copies of bit W/2-1 for a signed operation. With L=1, `busy` never rises.
- R7: In the small build, every multiply and multiply-accumulate has L=W, whatever the operand values.
- R8: In both builds, every divide has L=`DIV_LAT`.
- R9: HI and LO do not change while `busy` stays high. They change only on the accepting edge (when L=1) or on the edge that ends the operation.
- R10: `req_ready` is low while `busy` is high. A request held during that time is taken on the first edge at which the unit is idle. The result of the earlier operation is intact at that point.
- R11: `rd_stall` is high only when `rd_req` is high while the unit is busy. Being busy with `rd_req` low never raises it.
- R12: A reserved opcode is accepted but leaves HI and LO unchanged, and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit can accept a request this cycle |
| req_op | input | 3 | Opcode: class in [2:1], unsigned flag in [0] |
| src_a | input | W | First operand (multiplicand or dividend) |
| src_b | input | W | Second operand (multiplier or divisor) |
| rd_req | input | 1 | Pipeline wants to read HI or LO this cycle |
| rd_stall | output | 1 | Hold the dependent read |
| busy | output | 1 | A multi-cycle operation is in progress |
| hi | output | W | High result word |
| lo | output | W | Low result word |

## Verification
Both builds are instantiated at an 8-bit width. Every opcode is swept over a grid of dividends or multiplicands crossed with divisors or multipliers. The grid includes zero, one, all ones, the most negative value, and values on either side of the half-word range. The two sides of the half-word range tell the one-pass latency apart from the two-pass latency in the fast build. Zero and minus one as divisors expose the divide-by-zero rule and the wrap of the most negative quotient. The accumulate sweeps run as one long chain, so that a single wrong product or carry into HI shows in every later value. Separate sequences hold a second request during a small-build multiply, read HI/LO while busy, and issue reserved opcodes.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S = 3'd0,
        OP_MUL_U = 3'd1,
        OP_MAC_S = 3'd2,
        OP_MAC_U = 3'd3,
        OP_DIV_S = 3'd4,
        OP_DIV_U = 3'd5,
        OP_RSV_A = 3'd6,
        OP_RSV_B = 3'd7
    } mdu_op_e;

    typedef enum logic [1:0] {
        CLS_MUL  = 2'd0,
        CLS_MAC  = 2'd1,
        CLS_DIV  = 2'd2,
        CLS_NONE = 2'd3
    } mdu_cls_e;

    function automatic mdu_cls_e op_class(input logic [2:0] op);
        return mdu_cls_e'(op[2:1]);
    endfunction

    function automatic logic op_unsigned(input logic [2:0] op);
        return op[0];
    endfunction

endpackage

// File: rtl/mdu_mul_array.sv
module mdu_mul_array #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           uns,
    input  logic           b_short,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    localparam int HW = W / 2;
    localparam int AW = W + HW + 2;

    logic [W:0]       a_q;
    logic [HW:0]      bh_q;
    logic [2*W-1:0]   part_q;
    logic [W:0]       a_ext;
    logic [HW:0]      b_lo_ext;
    logic [HW:0]      b_hi_ext;
    logic [W:0]       opa;
    logic [HW:0]      opb;
    logic signed [AW-1:0] arr;
    logic [2*W-1:0]   arr_ext;

    assign a_ext    = {~uns & a[W-1], a};
    assign b_lo_ext = {~uns & b_short & b[HW-1], b[HW-1:0]};
    assign b_hi_ext = {~uns & b[W-1], b[W-1:HW]};

    // the single array: low half on the accepting cycle, high half after
    assign opa = start ? a_ext : a_q;
    assign opb = start ? b_lo_ext : bh_q;
    assign arr = $signed(opa) * $signed(opb);
    assign arr_ext = {{(2*W-AW){arr[AW-1]}}, arr};

    assign prod = start ? arr_ext : part_q + (arr_ext << HW);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            bh_q   <= '0;
            part_q <= '0;
        end else if (start) begin
            a_q    <= a_ext;
            bh_q   <= b_hi_ext;
            part_q <= arr_ext;
        end
    end
endmodule

// File: rtl/mdu_mul_iter.sv
module mdu_mul_iter #(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic           step,
    input  logic           uns,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] prod
);
    logic [2*W-1:0] acc_q, mc_q;
    logic [W-1:0]   mp_q;
    logic           neg_q;
    logic [W-1:0]   mag_a, mag_b;
    logic [2*W-1:0] s_acc, s_mc, n_acc, n_mc;
    logic [W-1:0]   s_mp, n_mp;
    logic           s_neg;

    assign mag_a = (!uns && a[W-1]) ? -a : a;
    assign mag_b = (!uns && b[W-1]) ? -b : b;

    assign s_acc = start ? '0 : acc_q;
    assign s_mc  = start ? {{W{1'b0}}, mag_a} : mc_q;
    assign s_mp  = start ? mag_b : mp_q;
    assign s_neg = start ? (!uns && (a[W-1] ^ b[W-1])) : neg_q;

    // one multiplier bit per step
    assign n_acc = s_acc + (s_mp[0] ? s_mc : '0);
    assign n_mc  = s_mc << 1;
    assign n_mp  = s_mp >> 1;

    assign prod = s_neg ? -n_acc : n_acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            mc_q  <= '0;
            mp_q  <= '0;
            neg_q <= 1'b0;
        end else if (start || step) begin
            acc_q <= n_acc;
            mc_q  <= n_mc;
            mp_q  <= n_mp;
            neg_q <= s_neg;
        end
    end
endmodule

// File: rtl/mdu_div_iter.sv
module mdu_div_iter #(
    parameter int W   = 32,
    parameter int LAT = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic         uns,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);
    // bits per clock chosen so the whole quotient is ready before edge LAT
    localparam int DSTEP = (W + LAT - 2) / (LAT - 1);
    localparam int NSTEP = W / DSTEP;
    localparam int CW    = $clog2(NSTEP + 1);

    logic [W-1:0]  rem_q, quo_q, dv_q;
    logic          negq_q, negr_q;
    logic [CW-1:0] left_q;
    logic [W-1:0]  mag_a, mag_b;
    logic [W-1:0]  s_rem, s_quo, s_dv;
    logic [W-1:0]  n_rem, n_quo;

    assign mag_a = (!uns && a[W-1]) ? -a : a;
    assign mag_b = (!uns && b[W-1]) ? -b : b;

    assign s_rem = start ? '0 : rem_q;
    assign s_quo = start ? mag_a : quo_q;
    assign s_dv  = start ? mag_b : dv_q;

    always_comb begin
        logic [W:0] t;
        n_rem = s_rem;
        n_quo = s_quo;
        for (int k = 0; k < DSTEP; k++) begin
            t     = {n_rem, n_quo[W-1]};
            n_quo = {n_quo[W-2:0], 1'b0};
            if (t >= {1'b0, s_dv}) begin
                t        = t - {1'b0, s_dv};
                n_quo[0] = 1'b1;
            end
            n_rem = t[W-1:0];
        end
    end

    assign quo = negq_q ? -quo_q : quo_q;
    assign rem = negr_q ? -rem_q : rem_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            quo_q  <= '0;
            dv_q   <= '0;
            negq_q <= 1'b0;
            negr_q <= 1'b0;
            left_q <= '0;
        end else if (start) begin
            rem_q  <= n_rem;
            quo_q  <= n_quo;
            dv_q   <= mag_b;
            negq_q <= !uns && (a[W-1] ^ b[W-1]);
            negr_q <= !uns && a[W-1];
            left_q <= CW'(NSTEP - 1);
        end else if (left_q != '0) begin
            rem_q  <= n_rem;
            quo_q  <= n_quo;
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
    import muldiv_pkg::*;
#(
    parameter int W          = 32,
    parameter int FAST_BUILD = 1,
    parameter int DIV_LAT    = 25
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req_valid,
    output logic         req_ready,
    input  logic [2:0]   req_op,
    input  logic [W-1:0] src_a,
    input  logic [W-1:0] src_b,
    input  logic         rd_req,
    output logic         rd_stall,
    output logic         busy,
    output logic [W-1:0] hi,
    output logic [W-1:0] lo
);
    localparam int HW      = W / 2;
    localparam int MUL_LAT = (FAST_BUILD != 0) ? 2 : W;
    localparam int LAT_MAX = (MUL_LAT > DIV_LAT) ? MUL_LAT : DIV_LAT;
    localparam int LW      = $clog2(LAT_MAX + 1);

    mdu_cls_e       cls_in, cls_q, wr_cls;
    logic           uns_in, b_short, issue, busy_q;
    logic [LW-1:0]  cnt_q, lat_q, issue_lat;
    logic [2*W-1:0] prod, hilo_q, wr_val;
    logic [W-1:0]   div_q, div_r;
    logic [HW-1:0]  b_top;

    assign cls_in = op_class(req_op);
    assign uns_in = op_unsigned(req_op);
    assign issue  = req_valid && !busy_q;

    assign b_top   = src_b[W-1:HW];
    assign b_short = uns_in ? (b_top == '0) : (b_top == {HW{src_b[HW-1]}});

    always_comb begin
        case (cls_in)
            CLS_MUL, CLS_MAC: begin
                if (FAST_BUILD != 0) issue_lat = b_short ? LW'(1) : LW'(2);
                else                 issue_lat = LW'(MUL_LAT);
            end
            CLS_DIV: issue_lat = LW'(DIV_LAT);
            default: issue_lat = '0;
        endcase
    end

    generate
        if (FAST_BUILD != 0) begin : g_fast
            mdu_mul_array #(.W(W)) u_mul (
                .clk    (clk),
                .rst    (rst),
                .start  (issue && !req_op[2]),
                .uns    (uns_in),
                .b_short(b_short),
                .a      (src_a),
                .b      (src_b),
                .prod   (prod)
            );
        end else begin : g_small
            mdu_mul_iter #(.W(W)) u_mul (
                .clk  (clk),
                .rst  (rst),
                .start(issue && !req_op[2]),
                .step (busy_q),
                .uns  (uns_in),
                .a    (src_a),
                .b    (src_b),
                .prod (prod)
            );
        end
    endgenerate

    mdu_div_iter #(.W(W), .LAT(DIV_LAT)) u_div (
        .clk  (clk),
        .rst  (rst),
        .start(issue && (cls_in == CLS_DIV)),
        .uns  (uns_in),
        .a    (src_a),
        .b    (src_b),
        .quo  (div_q),
        .rem  (div_r)
    );

    assign wr_cls = busy_q ? cls_q : cls_in;

    always_comb begin
        case (wr_cls)
            CLS_MAC: wr_val = hilo_q + prod;
            CLS_DIV: wr_val = {div_r, div_q};
            default: wr_val = prod;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            lat_q  <= '0;
            cls_q  <= CLS_NONE;
            hilo_q <= '0;
        end else if (issue) begin
            cls_q  <= cls_in;
            lat_q  <= issue_lat;
            cnt_q  <= LW'(1);
            busy_q <= (issue_lat > LW'(1));
            if (issue_lat == LW'(1)) hilo_q <= wr_val;
        end else if (busy_q) begin
            if (cnt_q == lat_q - LW'(1)) begin
                busy_q <= 1'b0;
                hilo_q <= wr_val;
            end else begin
                cnt_q <= cnt_q + LW'(1);
            end
        end
    end

    assign req_ready = !busy_q;
    assign busy      = busy_q;
    assign rd_stall  = rd_req && busy_q;
    assign hi        = hilo_q[2*W-1:W];
    assign lo        = hilo_q[W-1:0];
endmodule

// File: rtl/mdu_chk.sv
module mdu_chk #(
    parameter int W          = 32,
    parameter int FAST_BUILD = 1,
    parameter int DIV_LAT    = 25
) (
    input logic         clk,
    input logic         rst,
    input logic         req_valid,
    input logic         req_ready,
    input logic [2:0]   req_op,
    input logic [W-1:0] src_b,
    input logic         busy,
    input logic [W-1:0] hi,
    input logic [W-1:0] lo
);
    localparam int HW = W / 2;

    logic     accept, is_mul, short_b;
    int       exp_lat, exp_q, run_q;

    assign accept  = req_valid && req_ready;
    assign is_mul  = !req_op[2];
    assign short_b = req_op[0] ? (src_b[W-1:HW] == '0)
                               : (src_b[W-1:HW] == {HW{src_b[HW-1]}});

    always_comb begin
        if (req_op[2:1] == 2'b11)  exp_lat = 0;
        else if (req_op[2])        exp_lat = DIV_LAT;
        else if (FAST_BUILD != 0)  exp_lat = short_b ? 1 : 2;
        else                       exp_lat = W;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            exp_q <= 0;
            run_q <= 0;
        end else if (accept) begin
            exp_q <= exp_lat;
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end
    end

    AST_HILO_FROZEN: assert property (@(posedge clk) disable iff (rst)
        busy && $past(busy) |-> $stable(hi) && $stable(lo));  // R9

    AST_LAT_EXACT: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> run_q == exp_q - 1);  // R8

    AST_SHORT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (FAST_BUILD != 0) && accept && is_mul && short_b |=> !busy);  // R6

    AST_FULL_PAIR: assert property (@(posedge clk) disable iff (rst)
        (FAST_BUILD != 0) && accept && is_mul && !short_b |=> busy ##1 !busy);  // R6

    AST_RSV_NOP: assert property (@(posedge clk) disable iff (rst)
        accept && (req_op[2:1] == 2'b11) |=> !busy && $stable(hi) && $stable(lo));  // R12

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        accept && (req_op[2:1] == 2'b10) |=> busy);  // R8
endmodule

bind muldiv_unit mdu_chk #(.W(W), .FAST_BUILD(FAST_BUILD), .DIV_LAT(DIV_LAT)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_op   (req_op),
    .src_b    (src_b),
    .busy     (busy),
    .hi       (hi),
    .lo       (lo)
);

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;
    localparam int W  = 8;
    localparam int DL = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic valid = 1'b0;
    logic sel = 1'b0;
    logic [2:0] op = 3'd0;
    logic [W-1:0] a = '0, b = '0;
    logic rd_req = 1'b0;

    logic rdy_f, stall_f, busy_f, rdy_s, stall_s, busy_s;
    logic [W-1:0] hi_f, lo_f, hi_s, lo_s;
    logic rdy_m, stall_m, busy_m;
    logic [2*W-1:0] hilo_m;

    int n_run = 0;
    int n_fail = 0;
    logic [2*W-1:0] model = '0;

    always #4 clk = ~clk;

    muldiv_unit #(.W(W), .FAST_BUILD(1), .DIV_LAT(DL)) u_dut (
        .clk(clk), .rst(rst), .req_valid(valid && !sel), .req_ready(rdy_f),
        .req_op(op), .src_a(a), .src_b(b), .rd_req(rd_req), .rd_stall(stall_f),
        .busy(busy_f), .hi(hi_f), .lo(lo_f));

    muldiv_unit #(.W(W), .FAST_BUILD(0), .DIV_LAT(DL)) u_dut_sm (
        .clk(clk), .rst(rst), .req_valid(valid && sel), .req_ready(rdy_s),
        .req_op(op), .src_a(a), .src_b(b), .rd_req(rd_req), .rd_stall(stall_s),
        .busy(busy_s), .hi(hi_s), .lo(lo_s));

    assign rdy_m   = sel ? rdy_s : rdy_f;
    assign stall_m = sel ? stall_s : stall_f;
    assign busy_m  = sel ? busy_s : busy_f;
    assign hilo_m  = sel ? {hi_s, lo_s} : {hi_f, lo_f};

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (build=%0d)", tag, act, exp, sel);
        end
    endtask

    function automatic logic [2*W-1:0] exp_val(input logic [2:0] o, input logic [W-1:0] x,
                                                input logic [W-1:0] y, input logic [2*W-1:0] acc);
        int sx, sy, ux, uy;
        logic [2*W-1:0] p;
        logic [W-1:0] q, r;
        sx = int'($signed(x)); sy = int'($signed(y)); ux = int'(x); uy = int'(y);
        case (o[2:1])
            2'b00, 2'b01: begin
                p = o[0] ? (2*W)'(ux * uy) : (2*W)'(sx * sy);
                if (o[2:1] == 2'b01) p = acc + p;
                return p;
            end
            2'b10: begin
                if (y == '0) begin
                    q = (!o[0] && x[W-1]) ? W'(1) : '1;
                    r = x;
                end else begin
                    q = o[0] ? W'(ux / uy) : W'(sx / sy);
                    r = o[0] ? W'(ux % uy) : W'(sx % sy);
                end
                return {r, q};
            end
            default: return acc;
        endcase
    endfunction

    function automatic int exp_lat(input logic [2:0] o, input logic [W-1:0] y);
        bit sh;
        sh = o[0] ? (y[W-1:W/2] == '0) : (y[W-1:W/2] == {(W/2){y[W/2-1]}});
        if (o[2:1] == 2'b11) return 0;
        if (o[2]) return DL;
        if (sel) return W;
        return sh ? 1 : 2;
    endfunction

    function automatic string res_tag(input logic [2:0] o, input logic [W-1:0] y);
        if (o[2:1] == 2'b01) return "R3 accumulate";
        if (o[2:1] == 2'b00) return "R2 product";
        if (y == '0) return "R5 divide by zero";
        return "R4 quotient/remainder";
    endfunction

    function automatic string lat_tag(input logic [2:0] o);
        if (o[2]) return "R8 divide latency";
        if (sel) return "R7 small multiply latency";
        return "R6 fast multiply latency";
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
        int n;
        logic [2*W-1:0] e;
        int el;
        e  = exp_val(o, x, y, model);
        el = exp_lat(o, y);
        @(negedge clk);
        op = o; a = x; b = y; valid = 1'b1;
        @(negedge clk);
        valid = 1'b0;
        n = 1;
        while (busy_m && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == el, lat_tag(o), n, el);
        chk(hilo_m == e, res_tag(o, y), hilo_m, e);
        model = e;
    endtask

    function automatic logic [W-1:0] aval(input int i);
        case (i)
            0: return 8'h00; 1: return 8'h01; 2: return 8'h7F;
            3: return 8'h80; 4: return 8'hFF; 5: return 8'h81;
            default: return W'((i * 73 + 11) & 255);
        endcase
    endfunction

    function automatic logic [W-1:0] bval(input int j);
        case (j)
            0: return 8'h00; 1: return 8'h01; 2: return 8'hFF; 3: return 8'h07;
            4: return 8'h08; 5: return 8'hF8; 6: return 8'hF7; 7: return 8'h80;
            8: return 8'h7F; 9: return 8'h10; 10: return 8'h0F; 11: return 8'hEF;
            default: return W'((j * 29 + 3) & 255);
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; valid = 1'b0; rd_req = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model = '0;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        logic [2*W-1:0] e1, e2, hold;
        int n;
        // R1 reset state on both builds
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({hi_f, lo_f} == '0 && !busy_f && rdy_f, "R1 reset fast", {hi_f, lo_f}, 0);
        chk({hi_s, lo_s} == '0 && !busy_s && rdy_s, "R1 reset small", {hi_s, lo_s}, 0);

        for (int s = 0; s < 2; s++) begin
            sel = s[0];
            do_reset();
            for (int o = 0; o < 6; o++)
                for (int i = 0; i < 20; i++)
                    for (int j = 0; j < 16; j++)
                        run_op(3'(o), aval(i), bval(j));
            // R12 reserved opcodes change nothing
            for (int o = 6; o < 8; o++) begin
                hold = hilo_m;
                @(negedge clk);
                op = 3'(o); a = 8'h5A; b = 8'hC3; valid = 1'b1;
                @(negedge clk);
                valid = 1'b0;
                chk(!busy_m && hilo_m == hold, "R12 reserved opcode", hilo_m, hold);
            end
        end

        // R9 R10 R11 on the small build: hold a divide behind a multiply
        sel = 1'b1;
        do_reset();
        e1 = exp_val(3'd0, 8'hD3, 8'h6B, model);
        e2 = exp_val(3'd4, 8'h9C, 8'h0B, e1);
        @(negedge clk);
        op = 3'd0; a = 8'hD3; b = 8'h6B; valid = 1'b1;
        @(negedge clk);
        op = 3'd4; a = 8'h9C; b = 8'h0B;
        chk(!rdy_m && busy_m, "R10 ready low while busy", rdy_m, 0);
        rd_req = 1'b0;
        #1;
        chk(!stall_m, "R11 busy alone does not stall", stall_m, 0);
        rd_req = 1'b1;
        #1;
        chk(stall_m, "R11 dependent read stalled", stall_m, 1);
        chk(hilo_m == '0, "R9 HI/LO unchanged while busy", hilo_m, 0);
        n = 1;
        while (busy_m && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == W, "R7 multiply under held request", n, W);
        chk(hilo_m == e1, "R10 earlier result intact", hilo_m, e1);
        chk(!stall_m, "R11 stall released when idle", stall_m, 0);
        @(negedge clk);
        valid = 1'b0;
        rd_req = 1'b0;
        chk(busy_m, "R10 held request taken when idle", busy_m, 1);
        n = 1;
        while (busy_m && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == DL, "R8 held divide latency", n, DL);
        chk(hilo_m == e2, "R4 held divide result", hilo_m, e2);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule